// File: doc/BRIEF.md
# Bordered Raster Timing Generator

This block produces the timing of a video raster from a pixel clock. Each axis is described by six lengths: sync, back porch, leading border, display area, trailing border and front porch. Pixels are counted on the horizontal axis and lines on the vertical axis. From these counts the block drives horizontal and vertical sync, a display-active strobe, a border-active strobe, and coordinates relative to the display area. It also drives a field indicator for interlaced output.

A flag word sets the polarity of each sync and controls interlacing. Interlacing can be given explicitly by the flag word or taken from a default-mode input. One flag combination is reserved. When it is applied, the block reports a configuration error and runs non-interlaced.

New timing is captured on a load strobe and held until the frame boundary. There it replaces the running set in a single step, so a frame never mixes old and new values.

Top module: `vtg_raster_timing`

## Requirements
- R1: A line lasts as many pixels as the sum of the six horizontal lengths. It passes through sync, back porch, leading border, display, trailing border and front porch in that order. Horizontal sync is high, before inversion, exactly during the sync pixels. A phase of length zero takes no pixel. Every output reflects the counter state one clock earlier.
- R2: The line counter advances on the last pixel of each line. A frame lasts as many lines as the sum of the six vertical lengths, in the same phase order. Vertical sync, before inversion and without half-line shift, is high on every pixel of the sync lines.
- R3: Flag bit 0 set inverts `hsync_o`. Flag bit 1 set inverts `vsync_o`.
- R4: `display_o` is high only when both axes are in their display phase. `border_o` is high when both axes are within border-or-display phases and `display_o` is low.
- R5: During display, `pix_x` and `line_y` give the offset from the first display pixel and the first display line. Outside display both are zero.
- R6: With flag bit 2 set, bit 3 enables interlaced sync and bit 4 enables field selection. With bit 2 clear, both follow `ilace_dflt`.
- R7: Bit 2 set with bit 3 clear and bit 4 set raises `cfg_err_o`. It then disables both interlaced sync and field selection.
- R8: A frame parity starts at 0 after reset and after each configuration apply. At each other frame boundary it toggles while interlaced sync or field selection is on, and is forced to 0 otherwise. `field_o` shows the parity when field selection is on, and is 0 otherwise.
- R9: With interlaced sync on and parity 1, the vertical sync window starts and ends half a line later, where half a line is floor(line length / 2) pixels.
- R10: `cfg_load` captures all timing inputs and the flag word. They take effect at the next frame boundary. A strobe on the boundary cycle itself applies its own values at that boundary. A later strobe before the boundary replaces an earlier one.
- R11: While reset is low, all outputs are 0. After reset, both counters start at 0 and the parameter default timing with flag word 0 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for timing and flags |
| cfg_h_sync | input | 12 | Horizontal sync length, pixels |
| cfg_h_back | input | 12 | Horizontal back porch, pixels |
| cfg_h_lead | input | 12 | Left border, pixels |
| cfg_h_disp | input | 12 | Horizontal display size, pixels |
| cfg_h_trail | input | 12 | Right border, pixels |
| cfg_h_front | input | 12 | Horizontal front porch, pixels |
| cfg_v_sync | input | 12 | Vertical sync length, lines |
| cfg_v_back | input | 12 | Vertical back porch, lines |
| cfg_v_lead | input | 12 | Top border, lines |
| cfg_v_disp | input | 12 | Vertical display size, lines |
| cfg_v_trail | input | 12 | Bottom border, lines |
| cfg_v_front | input | 12 | Vertical front porch, lines |
| cfg_flags | input | 5 | Polarity and interlace flag word |
| ilace_dflt | input | 1 | Interlace mode used when flag bit 2 is clear |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| border_o | output | 1 | Border region active |
| display_o | output | 1 | Display region active |
| pix_x | output | 12 | Pixel offset within display |
| line_y | output | 12 | Line offset within display |
| field_o | output | 1 | Field indicator |
| cfg_err_o | output | 1 | Reserved interlace combination applied |

## Verification
A load strobe and the frame boundary can fall in the same cycle. Besides the strobe's values, this cycle also decides whether the parity resets or toggles. The bench provokes it by stepping a reference model until its state is the last pixel of the last line, and then issuing the strobe on exactly that cycle. It also issues strobes at random points, which sometimes land on that cycle as well. It judges the result by comparing every output, on every cycle after the boundary, with the reference model. The sync period and the display window must change on the very next frame, and the field indicator must restart at 0.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the raster timing generator: phase encoding and
// flag bit positions. Assumes six phases per axis in fixed order.
package vtg_pkg;
    localparam int NUM_PH = 6;
    localparam int FLAG_W = 5;

    // Bit positions within the flag word (decoded by vtg_flag_decode).
    localparam int FL_INV_H = 0;
    localparam int FL_INV_V = 1;
    localparam int FL_VALID = 2;
    localparam int FL_ISYNC = 3;
    localparam int FL_FSEL  = 4;

    // Phase order along one axis; the numeric order is the time order.
    typedef enum logic [2:0] {
        PH_SYNC   = 3'd0,
        PH_BACK   = 3'd1,
        PH_LEAD   = 3'd2,
        PH_DISP   = 3'd3,
        PH_TRAIL  = 3'd4,
        PH_FRONT  = 3'd5
    } phase_e;
endpackage

// File: rtl/vtg_axis_decode.sv
`timescale 1ns/1ps
// Combinational decoder for one axis. From the six phase lengths and the
// current position it derives the phase, the last-position flag, the offset
// from the first display position and the axis total. Zero-length phases
// are skipped because the phase is found from cumulative boundaries.
// Assumes len[0] is sync and len[5] is front porch.
module vtg_axis_decode
    import vtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int SW = CW + 3
) (
    input  logic [NUM_PH-1:0][CW-1:0] len,
    input  logic [CW-1:0]             pos,
    output phase_e                    phase,
    output logic                      last,
    output logic [CW-1:0]             rel,
    output logic [SW-1:0]             total
);
    logic [NUM_PH-1:0][SW-1:0] cum;
    logic [SW-1:0]             acc;
    logic [SW-1:0]             pos_w;

    assign pos_w = SW'(pos);

    // Running sum of phase lengths: cum[i] is the end of phase i.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NUM_PH; i++) begin
            acc    = acc + SW'(len[i]);
            cum[i] = acc;
        end
    end

    // Earliest phase whose end lies beyond the position.
    always_comb begin
        phase = PH_FRONT;
        for (int i = NUM_PH - 1; i >= 0; i--) begin
            if (pos_w < cum[i]) phase = phase_e'(3'(i));
        end
    end

    assign total = cum[NUM_PH-1];
    assign last  = (pos_w + SW'(1) >= total) || (pos == '1);
    assign rel   = pos - cum[int'(PH_LEAD)][CW-1:0];
endmodule

// File: rtl/vtg_pos_counter.sv
`timescale 1ns/1ps
// Position counter for one axis. Steps by one when enabled and returns to
// zero after the last position. Assumes 'last' comes from the decoder of
// the same axis.
module vtg_pos_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          last,
    output logic [CW-1:0] pos
);
    // Advance or wrap the axis position.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (adv)  pos <= last ? '0 : pos + CW'(1);
    end

    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last) |=> (pos == '0));

    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pos));
endmodule

// File: rtl/vtg_flag_decode.sv
`timescale 1ns/1ps
// Decodes the active flag word into sync inversions and interlace controls.
// When the valid bit is clear both interlace controls follow the default
// input. The reserved combination (valid, no interlaced sync, field select)
// reports an error and disables interlacing.
module vtg_flag_decode
    import vtg_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic              dflt,
    output logic              inv_h,
    output logic              inv_v,
    output logic              isync,
    output logic              fsel,
    output logic              err
);
    logic valid;

    assign valid = flags[FL_VALID];
    assign inv_h = flags[FL_INV_H];
    assign inv_v = flags[FL_INV_V];
    assign err   = valid && !flags[FL_ISYNC] && flags[FL_FSEL];
    assign isync = valid ? flags[FL_ISYNC] : dflt;
    assign fsel  = valid ? (flags[FL_FSEL] && !err) : dflt;
endmodule

// File: rtl/vtg_raster_timing.sv
`timescale 1ns/1ps
// Bordered raster timing generator (top). Holds the active and pending
// timing sets, runs one decoder and counter per axis, tracks the frame
// parity and registers every output. Assumes the pixel clock drives clk and
// that line length and frame height fit the counter width.
module vtg_raster_timing
    import vtg_pkg::*;
#(
    parameter int CW        = 12,
    parameter int H_SYNC    = 2,
    parameter int H_BACK    = 2,
    parameter int H_LEAD    = 1,
    parameter int H_DISP    = 8,
    parameter int H_TRAIL   = 1,
    parameter int H_FRONT   = 2,
    parameter int V_SYNC    = 1,
    parameter int V_BACK    = 1,
    parameter int V_LEAD    = 1,
    parameter int V_DISP    = 4,
    parameter int V_TRAIL   = 1,
    parameter int V_FRONT   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [CW-1:0] cfg_h_sync,
    input  logic [CW-1:0] cfg_h_back,
    input  logic [CW-1:0] cfg_h_lead,
    input  logic [CW-1:0] cfg_h_disp,
    input  logic [CW-1:0] cfg_h_trail,
    input  logic [CW-1:0] cfg_h_front,
    input  logic [CW-1:0] cfg_v_sync,
    input  logic [CW-1:0] cfg_v_back,
    input  logic [CW-1:0] cfg_v_lead,
    input  logic [CW-1:0] cfg_v_disp,
    input  logic [CW-1:0] cfg_v_trail,
    input  logic [CW-1:0] cfg_v_front,
    input  logic [4:0]    cfg_flags,
    input  logic          ilace_dflt,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          border_o,
    output logic          display_o,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] line_y,
    output logic          field_o,
    output logic          cfg_err_o
);
    localparam int SW   = CW + 3;
    localparam int NAX  = 2;
    localparam logic [NUM_PH-1:0][CW-1:0] H_RST = {CW'(H_FRONT), CW'(H_TRAIL),
        CW'(H_DISP), CW'(H_LEAD), CW'(H_BACK), CW'(H_SYNC)};
    localparam logic [NUM_PH-1:0][CW-1:0] V_RST = {CW'(V_FRONT), CW'(V_TRAIL),
        CW'(V_DISP), CW'(V_LEAD), CW'(V_BACK), CW'(V_SYNC)};

    typedef logic [NUM_PH-1:0][CW-1:0] axis_len_t;

    axis_len_t [NAX-1:0]   in_len;
    axis_len_t [NAX-1:0]   act_len;
    axis_len_t [NAX-1:0]   pnd_len;
    logic [FLAG_W-1:0]     act_flags;
    logic [FLAG_W-1:0]     pnd_flags;
    logic                  pend_q;
    logic                  parity_q;

    logic [NAX-1:0][CW-1:0] pos;
    logic [NAX-1:0][CW-1:0] rel;
    logic [NAX-1:0][SW-1:0] total;
    logic [NAX-1:0]         last;
    logic [NAX-1:0]         adv;
    phase_e                 ph [NAX];

    logic inv_h, inv_v, isync, fsel, err;
    logic frame_end, apply;
    logic disp_now, region_now, vs_plain, vs_late, vs_raw;
    logic [SW-1:0] half_line;
    logic [SW-1:0] hpos_w;
    logic [CW-1:0] vs_len;

    assign in_len[0] = {cfg_h_front, cfg_h_trail, cfg_h_disp,
                        cfg_h_lead, cfg_h_back, cfg_h_sync};
    assign in_len[1] = {cfg_v_front, cfg_v_trail, cfg_v_disp,
                        cfg_v_lead, cfg_v_back, cfg_v_sync};

    // Horizontal counter runs every clock; vertical steps at line end.
    assign adv[0] = 1'b1;
    assign adv[1] = last[0];

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        vtg_axis_decode #(.CW(CW), .SW(SW)) u_dec (
            .len   (act_len[a]),
            .pos   (pos[a]),
            .phase (ph[a]),
            .last  (last[a]),
            .rel   (rel[a]),
            .total (total[a])
        );

        vtg_pos_counter #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv[a]),
            .last  (last[a]),
            .pos   (pos[a])
        );

        a_r2_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            (total[a] != '0) |-> ((SW'(pos[a]) < total[a]) || (pos[a] == '1)));
    end

    vtg_flag_decode u_flags (
        .flags (act_flags),
        .dflt  (ilace_dflt),
        .inv_h (inv_h),
        .inv_v (inv_v),
        .isync (isync),
        .fsel  (fsel),
        .err   (err)
    );

    assign frame_end = last[0] && last[1];
    assign apply     = frame_end && (cfg_load || pend_q);

    // Capture on strobe, swap into the active set at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_len   <= {V_RST, H_RST};
            pnd_len   <= {V_RST, H_RST};
            act_flags <= '0;
            pnd_flags <= '0;
            pend_q    <= 1'b0;
        end else if (apply) begin
            act_len   <= cfg_load ? in_len    : pnd_len;
            act_flags <= cfg_load ? cfg_flags : pnd_flags;
            pend_q    <= 1'b0;
        end else if (cfg_load) begin
            pnd_len   <= in_len;
            pnd_flags <= cfg_flags;
            pend_q    <= 1'b1;
        end
    end

    // Frame parity: restart on apply, toggle per frame while interlaced.
    always_ff @(posedge clk) begin
        if (!rst_n)         parity_q <= 1'b0;
        else if (frame_end) parity_q <= apply ? 1'b0 : ((isync || fsel) && !parity_q);
    end

    // Region and sync decode for the current counter state.
    always_comb begin
        hpos_w     = SW'(pos[0]);
        half_line  = total[0] >> 1;
        vs_len     = act_len[1][int'(PH_SYNC)];
        disp_now   = (ph[0] == PH_DISP) && (ph[1] == PH_DISP);
        region_now = (ph[0] >= PH_LEAD) && (ph[0] <= PH_TRAIL) &&
                     (ph[1] >= PH_LEAD) && (ph[1] <= PH_TRAIL);
        vs_plain   = (ph[1] == PH_SYNC);
        vs_late    = (vs_len != '0) &&
                     (((pos[1] < vs_len) && ((pos[1] != '0) || (hpos_w >= half_line))) ||
                      ((pos[1] == vs_len) && (hpos_w < half_line)));
        vs_raw     = (isync && parity_q) ? vs_late : vs_plain;
    end

    // Output register stage: one clock after the counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o   <= 1'b0;
            vsync_o   <= 1'b0;
            border_o  <= 1'b0;
            display_o <= 1'b0;
            pix_x     <= '0;
            line_y    <= '0;
            field_o   <= 1'b0;
            cfg_err_o <= 1'b0;
        end else begin
            hsync_o   <= (ph[0] == PH_SYNC) ^ inv_h;
            vsync_o   <= vs_raw ^ inv_v;
            border_o  <= region_now && !disp_now;
            display_o <= disp_now;
            pix_x     <= disp_now ? rel[0] : '0;
            line_y    <= disp_now ? rel[1] : '0;
            field_o   <= fsel && parity_q;
            cfg_err_o <= err;
        end
    end

    a_r4_regions_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(display_o && border_o));

    a_r5_coords_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !display_o |-> ((pix_x == '0) && (line_y == '0)));

    a_r7_error_blocks_field: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !field_o);

    a_r10_apply_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(frame_end));

    a_r2_line_steps_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (pos[1] != $past(pos[1])) |-> $past(last[0]));
endmodule

// File: tb/vtg_raster_timing_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a cycle model of the requirements runs beside the
// design; random and directed timing sets are loaded at varied points.
module vtg_raster_timing_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld = 1'b0;
    logic dflt = 1'b0;
    logic [4:0] flg = '0;
    int   nin [12];

    logic hsync_o, vsync_o, border_o, display_o, field_o, cfg_err_o;
    logic [11:0] pix_x, line_y;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int mh, mv, par, pend, actf, pndf;
    int act [12];
    int pnd [12];
    int e_hs, e_vs, e_bd, e_dp, e_x, e_y, e_fd, e_er;
    int dflt_lens [12] = '{2, 2, 1, 8, 1, 2, 1, 1, 1, 4, 1, 1};

    always #2.5 clk = ~clk;

    vtg_raster_timing u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_load (ld),
        .cfg_h_sync (nin[0][11:0]), .cfg_h_back (nin[1][11:0]),
        .cfg_h_lead (nin[2][11:0]), .cfg_h_disp (nin[3][11:0]),
        .cfg_h_trail (nin[4][11:0]), .cfg_h_front (nin[5][11:0]),
        .cfg_v_sync (nin[6][11:0]), .cfg_v_back (nin[7][11:0]),
        .cfg_v_lead (nin[8][11:0]), .cfg_v_disp (nin[9][11:0]),
        .cfg_v_trail (nin[10][11:0]), .cfg_v_front (nin[11][11:0]),
        .cfg_flags (flg), .ilace_dflt (dflt),
        .hsync_o (hsync_o), .vsync_o (vsync_o), .border_o (border_o),
        .display_o (display_o), .pix_x (pix_x), .line_y (line_y),
        .field_o (field_o), .cfg_err_o (cfg_err_o)
    );

    task automatic chk(input int actual, input int expv, input string tag);
        checks++;
        if (actual != expv) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, actual, expv);
        end
    endtask

    function automatic int cum(input int base, input int k);
        int s = 0;
        for (int i = 0; i <= k; i++) s += act[base + i];
        return s;
    endfunction

    function automatic int phase_of(input int pos, input int base);
        for (int k = 0; k < 6; k++) if (pos < cum(base, k)) return k;
        return 5;
    endfunction

    function automatic int is_last(input int pos, input int base);
        return int'((pos + 1 >= cum(base, 5)) || (pos == 4095));
    endfunction

    // R6 R7: flag word interpretation
    task automatic fdec(input int f, input int d, output int ih, output int iv,
                        output int isy, output int fs, output int er);
        ih = f & 1;
        iv = (f >> 1) & 1;
        if (((f >> 2) & 1) == 1) begin
            er  = int'((((f >> 3) & 1) == 0) && (((f >> 4) & 1) == 1));
            isy = (f >> 3) & 1;
            fs  = (er == 1) ? 0 : ((f >> 4) & 1);
        end else begin
            er = 0; isy = int'(dflt); fs = int'(dflt);
        end
    endtask

    task automatic calc();
        int ih, iv, isy, fs, er, hp, vp, half, vsl, sh, vsr;
        fdec(actf, int'(dflt), ih, iv, isy, fs, er);
        hp   = phase_of(mh, 0);
        vp   = phase_of(mv, 6);
        half = cum(0, 5) / 2;
        vsl  = act[6];
        sh   = int'((vsl != 0) && (((mv < vsl) && ((mv != 0) || (mh >= half))) ||
                                   ((mv == vsl) && (mh < half))));
        vsr  = (isy == 1 && par == 1) ? sh : int'(vp == 0);
        e_hs = int'(hp == 0) ^ ih;
        e_vs = vsr ^ iv;
        e_dp = int'(hp == 3 && vp == 3);
        e_bd = int'(hp >= 2 && hp <= 4 && vp >= 2 && vp <= 4 && e_dp == 0);
        e_x  = (e_dp == 1) ? ((mh - cum(0, 2)) & 4095) : 0;
        e_y  = (e_dp == 1) ? ((mv - cum(6, 2)) & 4095) : 0;
        e_fd = fs & par;
        e_er = er;
    endtask

    task automatic advance();
        int ih, iv, isy, fs, er, hl, vl, fe, ap;
        fdec(actf, int'(dflt), ih, iv, isy, fs, er);
        hl = is_last(mh, 0);
        vl = is_last(mv, 6);
        fe = hl & vl;
        ap = fe & (int'(ld) | pend);
        mh = (hl == 1) ? 0 : mh + 1;
        if (hl == 1) mv = (vl == 1) ? 0 : mv + 1;
        if (fe == 1) par = (ap == 1) ? 0 : (((isy | fs) == 1) ? (par ^ 1) : 0);
        if (ap == 1) begin
            for (int i = 0; i < 12; i++) act[i] = (ld == 1'b1) ? nin[i] : pnd[i];
            actf = (ld == 1'b1) ? int'(flg) : pndf;
            pend = 0;
        end else if (ld == 1'b1) begin
            for (int i = 0; i < 12; i++) pnd[i] = nin[i];
            pndf = int'(flg);
            pend = 1;
        end
    endtask

    // One clock: predict, step model, let the edge pass, compare.
    task automatic cyc();
        calc();
        advance();
        @(negedge clk);
        chk(int'(hsync_o),   e_hs, "R1 R3 R10 hsync");
        chk(int'(vsync_o),   e_vs, "R2 R3 R9 vsync");
        chk(int'(display_o), e_dp, "R4 display");
        chk(int'(border_o),  e_bd, "R4 border");
        chk(int'(pix_x),     e_x,  "R5 pix_x");
        chk(int'(line_y),    e_y,  "R5 line_y");
        chk(int'(field_o),   e_fd, "R6 R8 field");
        chk(int'(cfg_err_o), e_er, "R7 cfg_err");
        ld = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic to_frame_end();
        while (!((is_last(mh, 0) == 1) && (is_last(mv, 6) == 1))) cyc();
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            to_frame_end();
            cyc();
        end
    endtask

    task automatic set_in(input int l0, l1, l2, l3, l4, l5,
                          input int v0, v1, v2, v3, v4, v5, input int f);
        nin[0] = l0; nin[1] = l1; nin[2] = l2; nin[3] = l3; nin[4] = l4; nin[5] = l5;
        nin[6] = v0; nin[7] = v1; nin[8] = v2; nin[9] = v3; nin[10] = v4; nin[11] = v5;
        flg = 5'(f);
    endtask

    task automatic rand_in();
        for (int i = 0; i < 12; i++) nin[i] = int'($urandom_range(0, 4));
        nin[0] = int'($urandom_range(1, 3));
        nin[3] = int'($urandom_range(1, 6));
        nin[6] = int'($urandom_range(0, 3));
        nin[9] = int'($urandom_range(1, 5));
        flg  = 5'($urandom_range(0, 31));
        dflt = 1'($urandom_range(0, 1));
    endtask

    initial begin
        for (int i = 0; i < 12; i++) nin[i] = 0;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11: outputs held low in reset
        chk(int'(hsync_o | vsync_o | border_o | display_o | field_o | cfg_err_o), 0, "R11 reset outputs");
        chk(int'(pix_x) + int'(line_y), 0, "R11 reset coords");
        mh = 0; mv = 0; par = 0; pend = 0; actf = 0; pndf = 0;
        for (int i = 0; i < 12; i++) begin act[i] = dflt_lens[i]; pnd[i] = dflt_lens[i]; end
        rst_n = 1'b1;
        // R1 R2 R4 R5: default timing, three frames
        frames(3);
        // R3 R10: inversion flags loaded mid-frame, pending until boundary
        run(37);
        set_in(3, 1, 2, 6, 2, 1, 2, 1, 1, 3, 1, 2, 3); ld = 1'b1;
        frames(2);
        // R10: two strobes before the boundary, the later one wins
        run(11);
        set_in(1, 1, 1, 5, 1, 1, 1, 1, 1, 3, 1, 1, 0); ld = 1'b1;
        run(20);
        set_in(2, 0, 0, 7, 0, 1, 1, 0, 0, 4, 0, 1, 1); ld = 1'b1;
        frames(2);
        // R7: reserved combination (bit2, bit4, no bit3)
        set_in(2, 1, 1, 6, 1, 1, 2, 1, 1, 3, 1, 1, 5'b10100); ld = 1'b1;
        frames(3);
        // R6 R8 R9: explicit interlaced sync and field select
        set_in(2, 2, 1, 6, 1, 3, 2, 1, 1, 3, 1, 1, 5'b11100); ld = 1'b1;
        frames(5);
        // R9: interlaced sync without field select
        set_in(3, 1, 1, 5, 1, 2, 1, 1, 0, 3, 0, 1, 5'b01110); ld = 1'b1;
        frames(4);
        // R6: bit2 clear, interlace follows default input
        dflt = 1'b1;
        set_in(2, 1, 1, 5, 1, 1, 2, 1, 1, 3, 1, 1, 5'b00000); ld = 1'b1;
        frames(4);
        dflt = 1'b0;
        frames(2);
        // R10: strobe on the exact boundary cycle applies at once
        to_frame_end();
        set_in(1, 0, 2, 4, 0, 2, 1, 0, 2, 2, 0, 1, 5'b11101); ld = 1'b1;
        cyc();
        frames(3);
        // R1 R2: zero-length phases skipped
        to_frame_end();
        set_in(0, 0, 0, 5, 0, 0, 0, 0, 0, 3, 0, 0, 0); ld = 1'b1;
        cyc();
        frames(2);
        // Random configurations at random strobe points
        for (int r = 0; r < 30; r++) begin
            run(int'($urandom_range(0, 60)));
            rand_in(); ld = 1'b1;
            frames(int'($urandom_range(1, 3)));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule